// File: doc/BRIEF.md
# USB Endpoint Handshake and Data-Toggle Control

This block holds the control state of one USB device endpoint. Software writes an 8-bit command byte through a plain register port. The byte can switch the endpoint on or off, ask for STALL answers, cancel a pending STALL request and return the data toggle to DATA0. The block combines those commands with events from the transaction engine. A SETUP-received strobe, a transaction-success strobe, the endpoint direction and the toggle of a received packet feed that state.

In return, the block tells the transaction engine three things: whether the endpoint takes part in handshakes at all, whether the answer must be STALL, and which toggle is expected next (OUT) or must be sent next (IN). For an OUT endpoint, a successful reception whose toggle differs from the expected one is reported as a duplicate for one cycle, and the toggle is left unchanged. The block has no streaming data path, so every pin is a plain level or strobe. Command bits 5, 4, 3 and 0 only act when written as 1 or take a written value, and they have no back-pressure.

Top module: `usb_ep_ctrl`

## Requirements
- R1: After reset, rd_data reads 0x00, and ep_active, send_stall, toggle and dup_pkt are all 0.
- R2: rd_data bits 7, 6, 4, 3, 2 and 1 always read 0. Values written to bits 7, 6, 2 and 1 are discarded.
- R3: A write sets the enable (bit 0 of wr_data) to the written value, and rd_data bit 0 and ep_active follow it from the next cycle.
- R4: A write with bit 5 = 1 to an enabled endpoint sets the STALL request, shown as rd_data bit 5 and send_stall. A write with bit 5 = 0 leaves the request unchanged.
- R5: A setup_rx pulse clears the STALL request in the next cycle, even when the same cycle writes bit 5 = 1.
- R6: A write with bit 4 = 1 clears the STALL request, even when bit 5 = 1 in the same write. Bit 4 itself never reads back as 1.
- R7: A write with bit 3 = 1 forces toggle to 0 (DATA0) in the next cycle. It overrides a same-cycle toggle advance, and the bit never reads back as 1.
- R8: For an IN endpoint (ep_dir_in = 1), xfer_ok while enabled and not stalled inverts toggle.
- R9: For an OUT endpoint, xfer_ok with rx_toggle equal to toggle inverts toggle. With rx_toggle different, toggle holds and dup_pkt is 1 for exactly the next cycle.
- R10: While disabled, ep_active is 0, send_stall and toggle are 0, xfer_ok has no effect, and a write that leaves bit 0 = 0 cannot set the STALL request.
- R11: xfer_ok while the STALL request is set does not change toggle and raises no dup_pkt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Command byte write strobe |
| wr_data | input | 8 | Command byte: bit 5 stall request, bit 4 stall cancel, bit 3 toggle reset, bit 0 enable |
| rd_data | output | 8 | Readback: bit 5 stall request, bit 0 enable, others 0 |
| setup_rx | input | 1 | SETUP packet received strobe |
| xfer_ok | input | 1 | Transaction completed with success strobe |
| ep_dir_in | input | 1 | Endpoint direction, 1 = IN, 0 = OUT |
| rx_toggle | input | 1 | Toggle of the received packet (OUT) |
| ep_active | output | 1 | Endpoint takes part in handshakes |
| send_stall | output | 1 | Answer the next handshake with STALL |
| toggle | output | 1 | Expected (OUT) or next sent (IN) data toggle |
| dup_pkt | output | 1 | One-cycle flag: last OUT packet was a duplicate |

## Verification
The hardest situations to reach are the collisions, where several events arrive in one cycle. Examples are a SETUP strobe arriving with a write that sets the STALL request, a toggle reset arriving with a successful transaction, or a disabling write arriving with a stall set. The stimulus runs directed sequences that line these up on purpose. A long random phase then drives every strobe independently each cycle, with the enable held on most of the time, so that stalled, duplicate and advancing transactions all meet software writes.

// File: rtl/usb_ep_ctrl_pkg.sv
package usb_ep_ctrl_pkg;
  localparam int CTRL_W        = 8;
  localparam int STALL_SET_BIT = 5;
  localparam int STALL_CLR_BIT = 4;
  localparam int TOG_RST_BIT   = 3;
  localparam int EN_BIT        = 0;

  typedef struct packed {
    logic en_wr;
    logic en_val;
    logic stall_set;
    logic stall_clr;
    logic tog_rst;
  } ep_cmd_t;
endpackage

// File: rtl/ep_cmd_decode.sv
module ep_cmd_decode
  import usb_ep_ctrl_pkg::*;
#(
  parameter int W = CTRL_W
) (
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output ep_cmd_t      cmd
);
  always_comb begin
    cmd.en_wr     = wr_en;
    cmd.en_val    = wr_data[EN_BIT];
    cmd.stall_set = wr_en & wr_data[STALL_SET_BIT];
    cmd.stall_clr = wr_en & wr_data[STALL_CLR_BIT];
    cmd.tog_rst   = wr_en & wr_data[TOG_RST_BIT];
  end
endmodule

// File: rtl/ep_ctrl_reg.sv
module ep_ctrl_reg
  import usb_ep_ctrl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ep_cmd_t cmd,
  input  logic    setup_rx,
  output logic    en_q,
  output logic    en_next,
  output logic    stall_q
);
  logic stall_n;

  always_comb begin
    en_next = cmd.en_wr ? cmd.en_val : en_q;
    stall_n = stall_q;
    if (cmd.stall_set) stall_n = 1'b1;
    if (cmd.stall_clr) stall_n = 1'b0;
    if (setup_rx)      stall_n = 1'b0;
    if (!en_next)      stall_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      en_q    <= en_next;
      stall_q <= stall_n;
    end
  end

  // R6
  stall_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.stall_clr |=> !stall_q);
  // R5
  setup_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_rx |=> !stall_q);
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && !cmd.stall_clr && !setup_rx && (!cmd.en_wr || cmd.en_val)) |=> stall_q);
  // R3
  en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.en_wr |=> (en_q == $past(cmd.en_val)));
endmodule

// File: rtl/ep_toggle.sv
module ep_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic en_next,
  input  logic stall_q,
  input  logic tog_rst,
  input  logic xfer_ok,
  input  logic dir_in,
  input  logic rx_tog,
  output logic tog_q,
  output logic dup_q
);
  logic acc, match, tog_n;

  always_comb begin
    acc   = xfer_ok & en_q & ~stall_q;
    match = dir_in | (rx_tog == tog_q);
    tog_n = tog_q;
    if (acc && match) tog_n = ~tog_q;
    if (tog_rst)      tog_n = 1'b0;
    if (!en_next)     tog_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      dup_q <= 1'b0;
    end else begin
      tog_q <= tog_n;
      dup_q <= acc & ~match;
    end
  end

  // R8
  in_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dir_in && !tog_rst && en_next) |=> (tog_q != $past(tog_q)));
  // R9
  dup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !dir_in && (rx_tog != tog_q) && !tog_rst && en_next) |=> (dup_q && tog_q == $past(tog_q)));
  // R7
  tog_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tog_rst |=> !tog_q);
  // R11
  stalled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ok && stall_q && !tog_rst && en_next) |=> (tog_q == $past(tog_q) && !dup_q));
endmodule

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl
  import usb_ep_ctrl_pkg::*;
#(
  parameter int W = CTRL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         setup_rx,
  input  logic         xfer_ok,
  input  logic         ep_dir_in,
  input  logic         rx_toggle,
  output logic         ep_active,
  output logic         send_stall,
  output logic         toggle,
  output logic         dup_pkt
);
  ep_cmd_t cmd;
  logic en_q, en_next, stall_q, tog_q, dup_q;

  ep_cmd_decode #(.W(W)) u_dec (
    .wr_en(wr_en), .wr_data(wr_data), .cmd(cmd)
  );

  ep_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .setup_rx(setup_rx),
    .en_q(en_q), .en_next(en_next), .stall_q(stall_q)
  );

  ep_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .en_next(en_next),
    .stall_q(stall_q), .tog_rst(cmd.tog_rst), .xfer_ok(xfer_ok),
    .dir_in(ep_dir_in), .rx_tog(rx_toggle), .tog_q(tog_q), .dup_q(dup_q)
  );

  always_comb begin
    rd_data                = '0;
    rd_data[EN_BIT]        = en_q;
    rd_data[STALL_SET_BIT] = stall_q;
  end

  assign ep_active  = en_q;
  assign send_stall = en_q & stall_q;
  assign toggle     = tog_q;
  assign dup_pkt    = dup_q;

  // R10
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_active |-> (!toggle && !send_stall));
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7:6] == 2'b00) && (rd_data[4:1] == 4'b0000));
endmodule

// File: tb/usb_ep_ctrl_bench.sv
module usb_ep_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       setup_rx = 1'b0, xfer_ok = 1'b0, ep_dir_in = 1'b0, rx_toggle = 1'b0;
  logic       ep_active, send_stall, toggle, dup_pkt;

  int checks = 0;
  int fails  = 0;
  bit m_en = 0, m_stall = 0, m_tog = 0, m_dup = 0;

  always #2 clk = ~clk;

  usb_ep_ctrl u_usb_ep_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .setup_rx(setup_rx), .xfer_ok(xfer_ok), .ep_dir_in(ep_dir_in), .rx_toggle(rx_toggle),
    .ep_active(ep_active), .send_stall(send_stall), .toggle(toggle), .dup_pkt(dup_pkt)
  );

  function automatic logic [7:0] exp_rd();
    return {2'b00, m_stall, 4'b0000, m_en};
  endfunction

  // model update from the requirements
  function automatic void model_step(bit w, logic [7:0] d, bit su, bit ok, bit din, bit rt);
    bit en_n, st_n, tg_n, acc, match;
    en_n  = w ? d[0] : m_en;
    st_n  = m_stall;
    if (w && d[5]) st_n = 1;           // R4
    if (w && d[4]) st_n = 0;           // R6
    if (su)        st_n = 0;           // R5
    if (!en_n)     st_n = 0;           // R10
    acc   = ok && m_en && !m_stall;    // R11
    match = din || (rt == m_tog);
    tg_n  = m_tog;
    if (acc && match) tg_n = !m_tog;   // R8, R9
    if (w && d[3]) tg_n = 0;           // R7
    if (!en_n)     tg_n = 0;
    m_dup   = acc && !match;
    m_en    = en_n;
    m_stall = st_n;
    m_tog   = tg_n;
  endfunction

  task automatic chk1(string tag, string nm, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk1(tag, "rd_data", rd_data, exp_rd());
    chk1(tag, "ep_active", {7'd0, ep_active}, {7'd0, m_en});
    chk1(tag, "send_stall", {7'd0, send_stall}, {7'd0, m_en & m_stall});
    chk1(tag, "toggle", {7'd0, toggle}, {7'd0, m_tog});
    chk1(tag, "dup_pkt", {7'd0, dup_pkt}, {7'd0, m_dup});
  endtask

  // drive at negedge, clock once, compare at next negedge
  task automatic cyc(string tag, bit w, logic [7:0] d, bit su, bit ok, bit din, bit rt);
    wr_en = w; wr_data = d; setup_rx = su; xfer_ok = ok; ep_dir_in = din; rx_toggle = rt;
    model_step(w, d, su, ok, din, rt);
    @(negedge clk);
    wr_en = 0; wr_data = 8'h00; setup_rx = 0; xfer_ok = 0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1;
    @(negedge clk);
    check_all("R1 after release");

    cyc("R10 stall while off",    1, 8'h20, 0, 0, 1, 0);
    cyc("R3 enable",              1, 8'h01, 0, 0, 1, 0);
    cyc("R2 reserved bits",       1, 8'hC7, 0, 0, 1, 0);
    cyc("R8 IN advance",          0, 8'h00, 0, 1, 1, 0);
    cyc("R8 IN advance again",    0, 8'h00, 0, 1, 1, 0);
    cyc("R8 IN advance 3",        0, 8'h00, 0, 1, 1, 0);
    cyc("R7 toggle reset",        1, 8'h09, 0, 0, 1, 0);
    cyc("R4 stall set",           1, 8'h21, 0, 0, 1, 0);
    cyc("R4 write 0 keeps stall", 1, 8'h01, 0, 0, 1, 0);
    cyc("R11 stalled xfer",       0, 8'h00, 0, 1, 1, 0);
    cyc("R11 stalled OUT",        0, 8'h00, 0, 1, 0, 1);
    cyc("R5 setup clears",        0, 8'h00, 1, 0, 0, 0);
    cyc("R5 setup beats set",     1, 8'h21, 1, 0, 0, 0);
    cyc("R6 clear beats set",     1, 8'h31, 0, 0, 0, 0);
    cyc("R6 clear alone",         1, 8'h21, 0, 0, 0, 0);
    cyc("R6 clear alone 2",       1, 8'h11, 0, 0, 0, 0);
    cyc("R9 OUT match",           0, 8'h00, 0, 1, 0, 0);
    cyc("R9 OUT duplicate",       0, 8'h00, 0, 1, 0, 0);
    cyc("R9 dup pulse ends",      0, 8'h00, 0, 0, 0, 0);
    cyc("R7 reset beats advance", 1, 8'h09, 0, 1, 0, 1);
    cyc("R4 stall again",         1, 8'h21, 0, 0, 1, 0);
    cyc("R10 disable",            1, 8'h20, 0, 0, 1, 0);
    cyc("R10 xfer while off",     0, 8'h00, 0, 1, 1, 0);

    for (int i = 0; i < 3000; i++) begin
      bit w, su, ok, din, rt;
      logic [7:0] d;
      w   = ($urandom % 4) == 0;
      d   = 8'($urandom);
      d[0] = ($urandom % 10) != 0;
      su  = ($urandom % 8) == 0;
      ok  = ($urandom % 2) == 0;
      din = ($urandom % 2) == 0;
      rt  = ($urandom % 2) == 0;
      cyc("R8/R9/R11 random", w, d, su, ok, din, rt);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule